// File: doc/BRIEF.md
# Two-Port Shared Word Memory Arbiter

This block lets two masters share one single-port memory that is 32 bits wide. One master is a tightly coupled processor data port. The other is a system-bus port, which carries DMA traffic and instruction fetches. Each port presents a request, a write flag, a word address, write data and four byte enables. In the same cycle it gets back a ready flag that says whether the memory served it. Read data comes back one cycle later on a separate valid/data pair that belongs to that port.

Each port works as valid/ready. `*_req` is the valid and `*_rdy` is the ready. A transfer completes in the cycle where both are high. When `*_rdy` is low the port is held off, and it must keep `*_req`, `*_we`, `*_addr`, `*_wdata` and `*_be` unchanged until a cycle with ready high. The read return has no back-pressure: the master must accept `*_rvalid` when it arrives.

A lone requester is served in the same cycle. When both ports request, the memory goes to the port that did not use it last, so the two ports take turns one word each. When neither port requests, the block remembers the last user. That port then wins immediately if it requests alone, and it yields first on the next contended cycle.

Top module: `sram_share_arb`

## Requirements
- R1: When exactly one port requests, that port's ready is high in the same cycle (zero wait states). Its access is performed in that cycle.
- R2: When both ports request in a cycle, only the port that was not the most recent user is ready. Over consecutive contended cycles the winner strictly alternates, so neither port waits more than one cycle.
- R3: In a cycle with no request, the record of the most recent user is unchanged.
- R4: After reset the most recent user is the processor data port. The first contended cycle after reset is therefore won by the bus port.
- R5: A port's ready is never high without its request, and at most one ready is high in any cycle.
- R6: A granted read (`*_we` = 0) raises that port's `*_rvalid` in the following cycle, with `*_rdata` equal to the addressed word. In every other cycle `*_rvalid` is 0 and `*_rdata` is 0. A granted write produces no read return.
- R7: A granted write changes only the bytes whose enable bit is 1. Bit i of `*_be` covers data bits 8i+7..8i, and the other bytes of the word keep their contents.
- R8: A held-off request that stays stable is eventually served, and it sees the memory contents at the cycle in which it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor port request (valid) |
| cpu_we | input | 1 | Processor port write flag |
| cpu_addr | input | AW | Processor port word address |
| cpu_wdata | input | 32 | Processor port write data |
| cpu_be | input | 4 | Processor port byte enables |
| cpu_rdy | output | 1 | Processor port served this cycle |
| cpu_rvalid | output | 1 | Processor port read data valid |
| cpu_rdata | output | 32 | Processor port read data |
| bus_req | input | 1 | Bus port request (valid) |
| bus_we | input | 1 | Bus port write flag |
| bus_addr | input | AW | Bus port word address |
| bus_wdata | input | 32 | Bus port write data |
| bus_be | input | 4 | Bus port byte enables |
| bus_rdy | output | 1 | Bus port served this cycle |
| bus_rvalid | output | 1 | Bus port read data valid |
| bus_rdata | output | 32 | Bus port read data |

## Verification
The alternation and starvation properties assume that a held-off port keeps its request asserted and its fields stable until ready. If a master dropped a refused request, the next contended cycle would not be a repeat of the same contest. The random stimulus honours this rule. Whenever the bench's model says a port was refused, the bench re-drives exactly the same request. It draws new values only for ports that were served or idle, and it limits addresses to a window that it preloads, so no read returns uninitialised data.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
  typedef enum logic {SIDE_CPU = 1'b0, SIDE_BUS = 1'b1} side_e;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
endpackage

// File: rtl/sram_arb_grant.sv
module sram_arb_grant
  import sram_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_cpu,
  input  logic  req_bus,
  output logic  gnt_cpu,
  output logic  gnt_bus,
  output side_e winner
);
  side_e park_q;
  logic  contend;

  assign contend = req_cpu & req_bus;

  always_comb begin
    if (contend)      winner = (park_q == SIDE_CPU) ? SIDE_BUS : SIDE_CPU;
    else if (req_bus) winner = SIDE_BUS;
    else if (req_cpu) winner = SIDE_CPU;
    else              winner = park_q;
  end

  assign gnt_cpu = req_cpu & (winner == SIDE_CPU);
  assign gnt_bus = req_bus & (winner == SIDE_BUS);

  always_ff @(posedge clk) begin
    if (!rst_n)                 park_q <= SIDE_CPU;
    else if (req_cpu | req_bus) park_q <= winner;
  end

  // checker state: previous contended cycle and who took it
  logic prev_con_q, prev_cpu_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_con_q <= 1'b0;
      prev_cpu_q <= 1'b0;
    end else begin
      prev_con_q <= contend;
      prev_cpu_q <= gnt_cpu;
    end
  end

  assert_solo_served_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cpu ^ req_bus) |-> (gnt_cpu | gnt_bus));

  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && prev_con_q) |-> (gnt_cpu != prev_cpu_q));

  assert_park_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_cpu | req_bus) |=> $stable(park_q));

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_cpu, gnt_bus}));
endmodule

// File: rtl/sram_port_sel.sv
module sram_port_sel
  import sram_arb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              gnt_cpu,
  input  logic              gnt_bus,
  input  side_e             winner,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [LANES-1:0]  cpu_be,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  output logic              m_en,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [WORD_W-1:0] m_wdata,
  output logic [LANES-1:0]  m_be
);
  logic pick_bus;
  assign pick_bus = (winner == SIDE_BUS);
  assign m_en     = gnt_cpu | gnt_bus;
  assign m_we     = m_en & (pick_bus ? bus_we : cpu_we);
  assign m_addr   = pick_bus ? bus_addr  : cpu_addr;
  assign m_wdata  = pick_bus ? bus_wdata : cpu_wdata;
  assign m_be     = pick_bus ? bus_be    : cpu_be;
endmodule

// File: rtl/sram_word_bank.sv
module sram_word_bank
  import sram_arb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (en && we && be[g]) cells[addr] <= wdata[g*8 +: 8];
      if (en && !we)         rd_q <= cells[addr];
    end
    assign rdata[g*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/sram_share_arb.sv
module sram_share_arb
  import sram_arb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_be,
  output logic              cpu_rdy,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic              bus_rdy,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata
);
  side_e             winner;
  logic              gnt_cpu, gnt_bus;
  logic              m_en, m_we;
  logic [AW-1:0]     m_addr;
  logic [WORD_W-1:0] m_wdata, m_rdata;
  logic [LANES-1:0]  m_be;
  logic              rv_cpu_q, rv_bus_q;

  sram_arb_grant u_grant (
    .clk(clk), .rst_n(rst_n), .req_cpu(cpu_req), .req_bus(bus_req),
    .gnt_cpu(gnt_cpu), .gnt_bus(gnt_bus), .winner(winner));

  sram_port_sel #(.AW(AW)) u_sel (
    .gnt_cpu(gnt_cpu), .gnt_bus(gnt_bus), .winner(winner),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be));

  sram_word_bank #(.AW(AW)) u_bank (
    .clk(clk), .en(m_en), .we(m_we), .addr(m_addr), .wdata(m_wdata),
    .be(m_be), .rdata(m_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_cpu_q <= 1'b0;
      rv_bus_q <= 1'b0;
    end else begin
      rv_cpu_q <= gnt_cpu & ~cpu_we;
      rv_bus_q <= gnt_bus & ~bus_we;
    end
  end

  assign cpu_rdy    = gnt_cpu;
  assign bus_rdy    = gnt_bus;
  assign cpu_rvalid = rv_cpu_q;
  assign bus_rvalid = rv_bus_q;
  assign cpu_rdata  = rv_cpu_q ? m_rdata : '0;
  assign bus_rdata  = rv_bus_q ? m_rdata : '0;

  assert_rdy_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy -> cpu_req) && (bus_rdy -> bus_req));

  assert_cpu_read_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_rdy && !cpu_we) |=> cpu_rvalid);

  assert_cpu_no_stray_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && cpu_rdy && !cpu_we) |=> !cpu_rvalid);

  assert_bus_read_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rdy && !bus_we) |=> bus_rvalid);

  assert_bus_no_stray_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_rdy && !bus_we) |=> !bus_rvalid);
endmodule

// File: tb/sram_share_arb_tb.sv
module sram_share_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cr = 0, cwe = 0, br = 0, bwe = 0;
  logic [AW-1:0] ca = '0, ba = '0;
  logic [31:0] cwd = '0, bwd = '0;
  logic [3:0] cbe = '0, bbe = '0;
  logic c_rdy, c_rv, b_rdy, b_rv;
  logic [31:0] c_rd, b_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_share_arb #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cr), .cpu_we(cwe), .cpu_addr(ca), .cpu_wdata(cwd), .cpu_be(cbe),
    .cpu_rdy(c_rdy), .cpu_rvalid(c_rv), .cpu_rdata(c_rd),
    .bus_req(br), .bus_we(bwe), .bus_addr(ba), .bus_wdata(bwd), .bus_be(bbe),
    .bus_rdy(b_rdy), .bus_rvalid(b_rv), .bus_rdata(b_rd));

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mem_m [16];
  logic park_m = 1'b0;           // 0 = processor port, 1 = bus port
  logic exp_c, exp_b;            // model grants of the last cycle
  logic prev_con = 0, prev_cpu_win = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] fill_val(input int i);
    return 32'h11223344 ^ (i * 32'h01010101);
  endfunction

  // Runs one cycle from a falling edge with inputs already driven.
  task automatic cycle_once();
    logic con, win, pc_v, pb_v;
    logic [31:0] pc_d, pb_d;
    #1;
    con = cr & br;
    if (con) win = ~park_m;
    else if (br) win = 1'b1;
    else if (cr) win = 1'b0;
    else win = park_m;
    exp_c = cr & ~win;
    exp_b = br & win;
    chk(c_rdy == exp_c, con ? "R2 cpu_rdy" : "R1 cpu_rdy", {31'd0, c_rdy}, {31'd0, exp_c});
    chk(b_rdy == exp_b, con ? "R2 bus_rdy" : "R1 bus_rdy", {31'd0, b_rdy}, {31'd0, exp_b});
    chk(!(c_rdy && !cr) && !(b_rdy && !br) && !(c_rdy && b_rdy), "R5 ready rule",
        {30'd0, c_rdy, b_rdy}, {30'd0, exp_c, exp_b});
    if (con && prev_con)
      chk(c_rdy != prev_cpu_win, "R2 alternation", {31'd0, c_rdy}, {31'd0, ~prev_cpu_win});
    prev_con = con;
    prev_cpu_win = c_rdy;
    pc_v = exp_c & ~cwe;  pc_d = mem_m[ca[3:0]];
    pb_v = exp_b & ~bwe;  pb_d = mem_m[ba[3:0]];
    if (exp_c & cwe) mem_m[ca[3:0]] = merge(mem_m[ca[3:0]], cwd, cbe);
    if (exp_b & bwe) mem_m[ba[3:0]] = merge(mem_m[ba[3:0]], bwd, bbe);
    if (cr | br) park_m = win;
    @(posedge clk);
    @(negedge clk);
    chk(c_rv == pc_v, "R6 cpu_rvalid", {31'd0, c_rv}, {31'd0, pc_v});
    chk(c_rd == (pc_v ? pc_d : 32'd0), "R8 cpu_rdata", c_rd, pc_v ? pc_d : 32'd0);
    chk(b_rv == pb_v, "R6 bus_rvalid", {31'd0, b_rv}, {31'd0, pb_v});
    chk(b_rd == (pb_v ? pb_d : 32'd0), "R8 bus_rdata", b_rd, pb_v ? pb_d : 32'd0);
  endtask

  task automatic set_cpu(input logic r, input logic w, input int a, input logic [31:0] d, input logic [3:0] e);
    cr = r; cwe = w; ca = AW'(a); cwd = d; cbe = e;
  endtask
  task automatic set_bus(input logic r, input logic w, input int a, input logic [31:0] d, input logic [3:0] e);
    br = r; bwe = w; ba = AW'(a); bwd = d; bbe = e;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!c_rdy && !b_rdy && !c_rv && !b_rv, "R5 reset idle", {28'd0, c_rdy, b_rdy, c_rv, b_rv}, 32'd0);
    rst_n = 1'b1;
    // R4: first contest after reset goes to the bus port
    set_cpu(1, 1, 0, 32'h0, 4'hF); set_bus(1, 1, 0, 32'h0, 4'hF);
    #1 chk(b_rdy && !c_rdy, "R4 first contest", {30'd0, c_rdy, b_rdy}, 32'd1);
    cycle_once();
    cycle_once();                       // cpu held, now served
    set_cpu(0, 0, 0, 0, 0);
    // preload window via bus alone (R1 zero wait)
    for (int i = 0; i < 16; i++) begin
      set_bus(1, 1, i, fill_val(i), 4'hF);
      cycle_once();
    end
    set_bus(0, 0, 0, 0, 0);
    // R3: idle keeps park on bus; contention then goes to cpu
    cycle_once(); cycle_once();
    set_cpu(1, 0, 1, 0, 0); set_bus(1, 0, 2, 0, 0);
    #1 chk(c_rdy && !b_rdy, "R3 park kept over idle", {30'd0, c_rdy, b_rdy}, 32'd2);
    cycle_once();
    set_cpu(0, 0, 0, 0, 0);
    cycle_once();                       // bus held read served (R8)
    set_bus(0, 0, 0, 0, 0);
    // R7: partial write lanes 0 and 2
    set_cpu(1, 1, 3, 32'hAABBCCDD, 4'b0101);
    cycle_once();
    set_cpu(1, 0, 3, 0, 0);
    cycle_once();
    chk(c_rd == 32'h12BB30DD, "R7 byte lanes", c_rd, 32'h12BB30DD);
    set_cpu(0, 0, 0, 0, 0);
    // R2: long contention with reads
    set_cpu(1, 0, 4, 0, 0); set_bus(1, 0, 5, 0, 0);
    for (int k = 0; k < 6; k++) cycle_once();
    // random phase; refused ports keep their request
    for (int k = 0; k < 4000; k++) begin
      if (!(cr && !exp_c))
        set_cpu(($urandom % 10) < 6, $urandom % 2, $urandom % 16, $urandom, 4'($urandom));
      if (!(br && !exp_b))
        set_bus(($urandom % 10) < 6, $urandom % 2, $urandom % 16, $urandom, 4'($urandom));
      cycle_once();
    end
    set_cpu(0, 0, 0, 0, 0); set_bus(0, 0, 0, 0, 0);
    cycle_once();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule